// File: doc/BRIEF.md
# Fast Interrupt Source Selector

This block routes one interrupt source to a dedicated fast-interrupt output. It watches three raw source vectors: a small base bank of eight lines and two wide banks of thirty-two lines each. A single control register chooses which line drives the fast output and whether that output is live at all. The selector numbers its sources in its own flat order: the first wide bank comes first, then the second wide bank, then the base bank.

Software programs the register through a plain write/read port. The output follows the raw level of the chosen line. No mask elsewhere in the interrupt system affects it. A line that is also enabled on the normal interrupt path fires on both outputs at once; this block never holds its output back for that reason. The port carries single register accesses, not a data stream, so it has no valid/ready handshake. A write or read takes effect on the clock edge where its strobe is high, and nothing can stall it.

Top module: `fiq_source_selector`

## Requirements
- R1: After reset the control register reads as zero and `fiq` is low.
- R2: A write with `wr_en` high and `addr` equal to 0x0C stores `wdata[6:0]` as the source index and `wdata[7]` as the enable bit. `wdata[31:8]` is dropped, and on read bits 31:8 return zero.
- R3: A write to any other address leaves the register unchanged. A read from any other address returns zero.
- R4: When `rd_en` is high, `rdata` shows the register value (as held before any write in that cycle) one clock later. In cycles with no read in the previous cycle, `rdata` is zero.
- R5: With the enable bit set, an index from 0 to 31 drives `fiq` from `bank1_src[index]`.
- R6: With the enable bit set, an index from 32 to 63 drives `fiq` from `bank2_src[index-32]`.
- R7: With the enable bit set, an index from 64 to 71 drives `fiq` from `bank0_src[index-64]`.
- R8: An index from 72 to 127 selects no line, and `fiq` stays low.
- R9: With the enable bit clear, `fiq` is low whatever the sources are. Writing zero to the register turns the fast output off.
- R10: `fiq` is registered. It equals (enable AND level of the selected line) as sampled at the previous clock edge, so it falls when the line falls. Lines that are not selected have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| bank0_src | input | 8 | Raw levels of the base bank |
| bank1_src | input | 32 | Raw levels of the first wide bank |
| bank2_src | input | 32 | Raw levels of the second wide bank |
| fiq | output | 1 | Fast interrupt output |

## Verification
A write lands in the register at the clock edge where it is strobed. `fiq` reflects the register and the source levels present at an edge one edge later, so a new setting shows on `fiq` two edges after the write strobe. Read data appears one edge after `rd_en`. The bench drives every input on the falling edge and samples on the falling edge after the edge that is due. After each register write it waits one additional cycle before it compares `fiq` with the value its model computes from the source vectors.

// File: rtl/fiq_sel_pkg.sv
package fiq_sel_pkg;
  parameter int IDX_W   = 7;
  parameter int BASE_W  = 8;
  parameter int WIDE_W  = 32;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 8;
  localparam int TOTAL_SRC = 2 * WIDE_W + BASE_W;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h0C;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } fiq_ctrl_t;
endpackage

// File: rtl/fiq_ctrl_reg.sv
module fiq_ctrl_reg
  import fiq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output fiq_ctrl_t         ctrl
);
  localparam int CW = IDX_W + 1;

  logic hit;
  fiq_ctrl_t ctrl_q;
  logic [DATA_W-1:0] rdata_q;

  assign hit = (addr == CTRL_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && hit)
      ctrl_q <= fiq_ctrl_t'(wdata[CW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd_en && hit)
      rdata_q <= {{(DATA_W-CW){1'b0}}, ctrl_q};
    else
      rdata_q <= '0;
  end

  assign ctrl  = ctrl_q;
  assign rdata = rdata_q;

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_OFS) |=> (ctrl_q == $past(wdata[CW-1:0])));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == CTRL_OFS) |=> $stable(ctrl_q));

  // R2
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CW] == '0);

  // R4
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/fiq_src_mux.sv
module fiq_src_mux
  import fiq_sel_pkg::*;
(
  input  logic [BASE_W-1:0] bank0_src,
  input  logic [WIDE_W-1:0] bank1_src,
  input  logic [WIDE_W-1:0] bank2_src,
  input  logic [IDX_W-1:0]  idx,
  output logic              level
);
  logic [TOTAL_SRC-1:0] flat;

  // Flat order: first wide bank, second wide bank, then base bank.
  for (genvar i = 0; i < TOTAL_SRC; i++) begin : g_flat
    if (i < WIDE_W) begin : g_b1
      assign flat[i] = bank1_src[i];
    end else if (i < 2 * WIDE_W) begin : g_b2
      assign flat[i] = bank2_src[i-WIDE_W];
    end else begin : g_b0
      assign flat[i] = bank0_src[i-2*WIDE_W];
    end
  end

  always_comb begin
    level = 1'b0;
    for (int k = 0; k < TOTAL_SRC; k++) begin
      if (int'(idx) == k) level = flat[k];
    end
  end

  // R8
  always_comb begin
    if (int'(idx) >= TOTAL_SRC) no_src_chk: assert (level == 1'b0);
  end
endmodule

// File: rtl/fiq_gate.sv
module fiq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  output logic fiq
);
  logic fiq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fiq_q <= 1'b0;
    else        fiq_q <= en & level;
  end

  assign fiq = fiq_q;

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fiq);

  // R10
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level) |=> fiq);
endmodule

// File: rtl/fiq_source_selector.sv
module fiq_source_selector
  import fiq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [BASE_W-1:0] bank0_src,
  input  logic [WIDE_W-1:0] bank1_src,
  input  logic [WIDE_W-1:0] bank2_src,
  output logic              fiq
);
  fiq_ctrl_t ctrl;
  logic      level;

  fiq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl(ctrl)
  );

  fiq_src_mux u_mux (
    .bank0_src(bank0_src), .bank1_src(bank1_src), .bank2_src(bank2_src),
    .idx(ctrl.idx), .level(level)
  );

  fiq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .level(level), .fiq(fiq)
  );

  // R5
  bank1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && int'(ctrl.idx) < WIDE_W && bank1_src[ctrl.idx[4:0]]) |=> fiq);

  // R7
  bank0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && int'(ctrl.idx) >= 2*WIDE_W && int'(ctrl.idx) < TOTAL_SRC
     && !bank0_src[ctrl.idx[2:0]]) |=> !fiq);

  // R8
  unmapped_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ctrl.idx) >= TOTAL_SRC) |=> !fiq);
endmodule

// File: tb/tb_fiq_source_selector.sv
module tb_fiq_source_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  bank0_src = '0;
  logic [31:0] bank1_src = '0, bank2_src = '0;
  logic        fiq;
  int checks = 0, errors = 0;
  logic [7:0] shadow = '0;

  always #10 clk = ~clk;

  fiq_source_selector dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bank0_src(bank0_src),
    .bank1_src(bank1_src), .bank2_src(bank2_src), .fiq(fiq)
  );

  function automatic logic model_fiq(logic [7:0] c, logic [7:0] b0,
                                     logic [31:0] b1, logic [31:0] b2);
    int i = int'(c[6:0]);
    if (!c[7]) return 1'b0;
    if (i < 32) return b1[i];
    if (i < 64) return b2[i-32];
    if (i < 72) return b0[i-64];
    return 1'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h0C) shadow = d[7:0];
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_fiq(string req);
    @(negedge clk);
    @(negedge clk);
    check(req, {31'b0, fiq}, {31'b0, model_fiq(shadow, bank0_src, bank1_src, bank2_src)});
  endtask

  initial begin
    logic [31:0] rd;
    #100000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4711));
    bank1_src = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 fiq", {31'b0, fiq}, 32'h0);
    read_reg(8'h0C, rd);
    check("R1 reg", rd, 32'h0);

    // R2 upper bits dropped
    write_reg(8'h0C, 32'hDEAD_BE85);
    read_reg(8'h0C, rd);
    check("R2 readback", rd, 32'h85);
    // R4 rdata zero without read
    @(negedge clk);
    check("R4 idle", rdata, 32'h0);

    // R3 other address ignored
    write_reg(8'h10, 32'h0000_00FF);
    read_reg(8'h0C, rd);
    check("R3 write ignored", rd, 32'h85);
    read_reg(8'h08, rd);
    check("R3 read other", rd, 32'h0);

    // R5 bank1 index 5
    bank1_src = 32'h0000_0020;
    write_reg(8'h0C, 32'h85);
    check_fiq("R5 bank1 hi");
    bank1_src = 32'hFFFF_FFDF;
    check_fiq("R10 unselected lines no effect");
    // R6 bank2 index 63 -> bank2[31]
    bank2_src = 32'h8000_0000;
    write_reg(8'h0C, 32'hBF);
    check_fiq("R6 bank2 top");
    // R7 bank0 index 71 and 64
    bank0_src = 8'h80;
    write_reg(8'h0C, 32'hC7);
    check_fiq("R7 bank0 idx71");
    write_reg(8'h0C, 32'hC0);
    check_fiq("R7 bank0 idx64 low");
    // R8 unmapped index
    bank0_src = 8'hFF; bank1_src = '1; bank2_src = '1;
    write_reg(8'h0C, 32'hC8);
    check_fiq("R8 idx72");
    write_reg(8'h0C, 32'hFF);
    check_fiq("R8 idx127");
    // R9 zero write turns off
    write_reg(8'h0C, 32'h80);
    check_fiq("R9 enabled idx0");
    write_reg(8'h0C, 32'h0);
    check_fiq("R9 off");
    // R10 timing: source falls, fiq falls one edge later
    write_reg(8'h0C, 32'h80);
    @(negedge clk);
    bank1_src[0] = 1'b0;
    @(negedge clk);
    check("R10 fall", {31'b0, fiq}, 32'h0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      bank0_src = 8'($urandom);
      bank1_src = $urandom;
      bank2_src = $urandom;
      if (n % 3 == 0) write_reg(8'h0C, {$urandom} & 32'h0000_01FF | 32'h80);
      check_fiq("R5 R6 R7 R8 R9 random");
      if (n % 25 == 0) begin
        read_reg(8'h0C, rd);
        check("R2 random readback", rd, {24'b0, shadow});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule